// File: doc/BRIEF.md
# Tower Selective Readout Filter

This block handles one readout tower of 25 channels for each triggered event. It takes in one beat per channel over a valid/ready handshake. Each beat carries the channel's ten 16-bit time samples. The first beat of a tower also carries a 2-bit interest class. A programmable table turns that class into a readout state:

- drop the tower,
- forward every channel, or
- forward only the channels whose amplitude estimate reaches a threshold.

The amplitude estimate is a signed weighted sum over all ten samples of a channel. Each sample is read as an unsigned 16-bit value and each weight is a signed 12-bit value.

Once the 25th beat has been accepted, the block stops taking input and plays out a compact stream. Each forwarded channel appears as a header word carrying its index, followed by its samples in time order. A closing word ends every tower, and this includes a dropped one. The block then accepts the next tower.

Top module: `sr_zs_unit`

## Requirements
- R1: `in_ready` is high while a tower is being collected. It is low from the cycle after the 25th beat is accepted until the cycle after the closing word, and beats offered while it is low are not taken.
- R2: The class is sampled only on a tower's first beat. Class 0 selects table entry `cfg_state_map[1:0]`, class 1 selects `[3:2]`, class 2 selects `[5:4]`, and class 3 also selects `[5:4]`.
- R3: State code 0 (drop) produces only a closing word, in the cycle right after the last beat is accepted. That word carries state 0 and count 0.
- R4: State code 1 (full) forwards all 25 channels in ascending index order. Each channel takes 11 consecutive valid cycles: the header, then sample 0 through sample 9.
- R5: In state code 2 (suppress), a channel is forwarded when sum over t of sample[t] × weight[t] ≥ `cfg_thresh`, computed as signed arithmetic. Sample t sits at `in_samples[16t+15:16t]` and weight t at `cfg_weights[12t+11:12t]`.
- R6: In suppress mode, each channel that is not forwarded takes exactly one cycle with `out_valid` low.
- R7: A header word has `out_kind` 1. Its data is the channel index in bits [4:0], with zeros above. A sample word has `out_kind` 2.
- R8: The closing word has `out_kind` 3. Its bits [15:14] hold the effective state, bits [4:0] hold the number of forwarded channels, and the bits between are zero.
- R9: A table entry of code 3 acts as full readout, and the closing word reports it as state 1.
- R10: After reset, `out_valid` is low, `in_ready` is high, and the next accepted beat counts as channel 0.
- R11: `out_valid` stays low while a tower is being collected.
- R12: The first output cycle of a tower comes in the cycle immediately after its 25th beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_state_map | input | 6 | Readout state per class slot (low, medium, high) |
| cfg_weights | input | 120 | Ten signed 12-bit filter weights |
| cfg_thresh | input | 33 | Signed keep threshold |
| in_valid | input | 1 | Channel beat offered |
| in_ready | output | 1 | Block can accept a beat |
| in_class | input | 2 | Tower interest class, used on first beat |
| in_samples | input | 160 | Ten 16-bit samples of one channel |
| out_valid | output | 1 | Output word present |
| out_kind | output | 2 | 1 header, 2 sample, 3 closing, 0 none |
| out_data | output | 16 | Output word |

## Verification
Every result is due at a fixed cycle counted from the edge that accepts the 25th beat. The first output slot appears in the next cycle. After that comes one cycle per sample, header or skipped channel. The closing word follows the last slot directly, and ready returns one cycle after the closing word. The bench builds the full per-cycle expectation for a tower at that accepting edge. It then compares one entry on every falling clock edge, so a word that comes early, late or missing shows up as a mismatch in that exact cycle. Threshold equality and threshold plus one are both exercised on the same channel.

// File: rtl/sr_zs_pkg.sv
package sr_zs_pkg;

    localparam int N_CH_D  = 25;
    localparam int N_SMP_D = 10;
    localparam int SMP_W_D = 16;
    localparam int WGT_W_D = 12;

    typedef enum logic [1:0] {
        RS_DROP    = 2'd0,
        RS_FULL    = 2'd1,
        RS_ZS      = 2'd2,
        RS_ALTFULL = 2'd3
    } rd_state_e;

    typedef enum logic [1:0] {
        OK_NONE = 2'd0,
        OK_HDR  = 2'd1,
        OK_SMP  = 2'd2,
        OK_END  = 2'd3
    } out_kind_e;

    typedef enum logic [1:0] {
        PH_COLLECT = 2'd0,
        PH_EMIT    = 2'd1,
        PH_END     = 2'd2
    } phase_e;

    // class 3 is reserved and shares the high-interest slot
    function automatic logic [1:0] class_slot(input logic [1:0] cls);
        return (cls == 2'd3) ? 2'd2 : cls;
    endfunction

    // table code 3 is reserved and behaves as full readout
    function automatic rd_state_e norm_state(input logic [1:0] code);
        return (code == 2'd3) ? RS_FULL : rd_state_e'(code);
    endfunction

endpackage

// File: rtl/sr_zs_fir.sv
module sr_zs_fir
    import sr_zs_pkg::*;
#(
    parameter int N_SMP = N_SMP_D,
    parameter int SMP_W = SMP_W_D,
    parameter int WGT_W = WGT_W_D,
    parameter int ACC_W = SMP_W + 1 + WGT_W + $clog2(N_SMP)
) (
    input  logic [N_SMP*SMP_W-1:0] samples,
    input  logic [N_SMP*WGT_W-1:0] weights,
    input  logic signed [ACC_W-1:0] thresh,
    output logic                    keep
);

    logic signed [ACC_W-1:0] s_ext [N_SMP];
    logic signed [ACC_W-1:0] w_ext [N_SMP];
    logic signed [ACC_W-1:0] prod  [N_SMP];
    logic signed [ACC_W-1:0] acc;

    generate
        for (genvar t = 0; t < N_SMP; t++) begin : g_tap
            assign s_ext[t] = ACC_W'($signed({1'b0, samples[t*SMP_W +: SMP_W]}));
            assign w_ext[t] = ACC_W'($signed(weights[t*WGT_W +: WGT_W]));
            assign prod[t]  = s_ext[t] * w_ext[t];
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int t = 0; t < N_SMP; t++) begin
            acc = acc + prod[t];
        end
        keep = (acc >= thresh);
    end

endmodule

// File: rtl/sr_zs_store.sv
module sr_zs_store
    import sr_zs_pkg::*;
#(
    parameter int N_CH  = N_CH_D,
    parameter int N_SMP = N_SMP_D,
    parameter int SMP_W = SMP_W_D,
    parameter int IDX_W = $clog2(N_CH),
    parameter int TAP_W = $clog2(N_SMP + 1),
    parameter int CNT_W = $clog2(N_CH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [N_SMP*SMP_W-1:0] wr_samples,
    input  logic                   wr_keep,
    input  logic [IDX_W-1:0]       rd_idx,
    input  logic [TAP_W-1:0]       rd_tap,
    output logic [SMP_W-1:0]       rd_word,
    output logic                   rd_keep,
    output logic [CNT_W-1:0]       keep_count
);

    logic [N_SMP*SMP_W-1:0] frame_mem [N_CH];
    logic [N_CH-1:0]        keep_q;
    logic [N_SMP*SMP_W-1:0] row;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            frame_mem[wr_idx] <= wr_samples;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            keep_q <= '0;
        end else if (wr_en) begin
            keep_q[wr_idx] <= wr_keep;
        end
    end

    always_comb begin
        row     = frame_mem[rd_idx];
        rd_word = row[rd_tap*SMP_W +: SMP_W];
        rd_keep = keep_q[rd_idx];
    end

    always_comb begin
        keep_count = '0;
        for (int c = 0; c < N_CH; c++) begin
            keep_count = keep_count + CNT_W'(keep_q[c]);
        end
    end

endmodule

// File: rtl/sr_zs_emit.sv
module sr_zs_emit
    import sr_zs_pkg::*;
#(
    parameter int N_CH  = N_CH_D,
    parameter int N_SMP = N_SMP_D,
    parameter int SMP_W = SMP_W_D,
    parameter int IDX_W = $clog2(N_CH),
    parameter int TAP_W = $clog2(N_SMP + 1),
    parameter int CNT_W = $clog2(N_CH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  rd_state_e        start_state,
    input  logic [SMP_W-1:0] rd_word,
    input  logic             rd_keep,
    input  logic [CNT_W-1:0] keep_count,
    output logic [IDX_W-1:0] rd_idx,
    output logic [TAP_W-1:0] rd_tap,
    output logic             busy,
    output logic             out_valid,
    output logic [1:0]       out_kind,
    output logic [SMP_W-1:0] out_data
);

    phase_e           ph_q;
    rd_state_e        st_q;
    logic [IDX_W-1:0] ch_q;
    logic [TAP_W-1:0] tap_q;
    logic             sel;
    logic             last_slot;
    logic [CNT_W-1:0] end_cnt;

    assign sel       = (st_q == RS_FULL) || ((st_q == RS_ZS) && rd_keep);
    assign last_slot = !sel || (tap_q == TAP_W'(N_SMP));
    assign rd_idx    = ch_q;
    assign rd_tap    = (tap_q == '0) ? '0 : tap_q - TAP_W'(1);
    assign busy      = (ph_q != PH_COLLECT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_COLLECT;
            st_q  <= RS_DROP;
            ch_q  <= '0;
            tap_q <= '0;
        end else begin
            case (ph_q)
                PH_COLLECT: begin
                    if (start) begin
                        st_q  <= start_state;
                        ch_q  <= '0;
                        tap_q <= '0;
                        ph_q  <= (start_state == RS_DROP) ? PH_END : PH_EMIT;
                    end
                end
                PH_EMIT: begin
                    if (last_slot) begin
                        tap_q <= '0;
                        if (ch_q == IDX_W'(N_CH - 1)) begin
                            ph_q <= PH_END;
                        end else begin
                            ch_q <= ch_q + IDX_W'(1);
                        end
                    end else begin
                        tap_q <= tap_q + TAP_W'(1);
                    end
                end
                default: begin
                    ph_q <= PH_COLLECT;
                end
            endcase
        end
    end

    always_comb begin
        case (st_q)
            RS_FULL: end_cnt = CNT_W'(N_CH);
            RS_ZS:   end_cnt = keep_count;
            default: end_cnt = '0;
        endcase
    end

    always_comb begin
        out_valid = 1'b0;
        out_kind  = OK_NONE;
        out_data  = '0;
        if (ph_q == PH_EMIT && sel) begin
            out_valid = 1'b1;
            if (tap_q == '0) begin
                out_kind               = OK_HDR;
                out_data[IDX_W-1:0]    = ch_q;
            end else begin
                out_kind = OK_SMP;
                out_data = rd_word;
            end
        end else if (ph_q == PH_END) begin
            out_valid              = 1'b1;
            out_kind               = OK_END;
            out_data[SMP_W-1 -: 2] = st_q;
            out_data[CNT_W-1:0]    = end_cnt;
        end
    end

endmodule

// File: rtl/sr_zs_unit.sv
module sr_zs_unit
    import sr_zs_pkg::*;
#(
    parameter int N_CH  = N_CH_D,
    parameter int N_SMP = N_SMP_D,
    parameter int SMP_W = SMP_W_D,
    parameter int WGT_W = WGT_W_D,
    localparam int ACC_W = SMP_W + 1 + WGT_W + $clog2(N_SMP),
    localparam int IDX_W = $clog2(N_CH),
    localparam int TAP_W = $clog2(N_SMP + 1),
    localparam int CNT_W = $clog2(N_CH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [5:0]              cfg_state_map,
    input  logic [N_SMP*WGT_W-1:0]  cfg_weights,
    input  logic signed [ACC_W-1:0] cfg_thresh,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [1:0]              in_class,
    input  logic [N_SMP*SMP_W-1:0]  in_samples,
    output logic                    out_valid,
    output logic [1:0]              out_kind,
    output logic [SMP_W-1:0]        out_data
);

    logic [IDX_W-1:0] col_q;
    rd_state_e        mode_q;
    rd_state_e        mode_now;
    logic             fire;
    logic             start;
    logic             keep;
    logic             busy;
    logic [IDX_W-1:0] rd_idx;
    logic [TAP_W-1:0] rd_tap;
    logic [SMP_W-1:0] rd_word;
    logic             rd_keep;
    logic [CNT_W-1:0] keep_count;
    logic [1:0]       slot;

    assign in_ready = !busy;
    assign fire     = in_valid && in_ready;
    assign start    = fire && (col_q == IDX_W'(N_CH - 1));
    assign slot     = class_slot(in_class);
    assign mode_now = norm_state(cfg_state_map[slot*2 +: 2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q  <= '0;
            mode_q <= RS_DROP;
        end else if (fire) begin
            col_q <= (col_q == IDX_W'(N_CH - 1)) ? '0 : col_q + IDX_W'(1);
            if (col_q == '0) begin
                mode_q <= mode_now;
            end
        end
    end

    sr_zs_fir #(
        .N_SMP(N_SMP), .SMP_W(SMP_W), .WGT_W(WGT_W), .ACC_W(ACC_W)
    ) u_fir (
        .samples(in_samples),
        .weights(cfg_weights),
        .thresh (cfg_thresh),
        .keep   (keep)
    );

    sr_zs_store #(
        .N_CH(N_CH), .N_SMP(N_SMP), .SMP_W(SMP_W),
        .IDX_W(IDX_W), .TAP_W(TAP_W), .CNT_W(CNT_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (fire),
        .wr_idx    (col_q),
        .wr_samples(in_samples),
        .wr_keep   (keep),
        .rd_idx    (rd_idx),
        .rd_tap    (rd_tap),
        .rd_word   (rd_word),
        .rd_keep   (rd_keep),
        .keep_count(keep_count)
    );

    sr_zs_emit #(
        .N_CH(N_CH), .N_SMP(N_SMP), .SMP_W(SMP_W),
        .IDX_W(IDX_W), .TAP_W(TAP_W), .CNT_W(CNT_W)
    ) u_emit (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_state(mode_q),
        .rd_word    (rd_word),
        .rd_keep    (rd_keep),
        .keep_count (keep_count),
        .rd_idx     (rd_idx),
        .rd_tap     (rd_tap),
        .busy       (busy),
        .out_valid  (out_valid),
        .out_kind   (out_kind),
        .out_data   (out_data)
    );

endmodule

// File: rtl/sr_zs_unit_chk.sv
module sr_zs_unit_chk #(
    parameter int N_CH  = 25,
    parameter int SMP_W = 16,
    localparam int IDX_W = $clog2(N_CH),
    localparam int CNT_W = $clog2(N_CH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic [1:0]       out_kind,
    input logic [SMP_W-1:0] out_data
);

    logic is_end;
    assign is_end = out_valid && (out_kind == 2'd3);

    p_busy_blocks_input_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    p_end_reopens_r1: assert property (@(posedge clk) disable iff (rst)
        is_end |=> in_ready);

    p_header_then_sample_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd1) |=> (out_valid && out_kind == 2'd2));

    p_header_format_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd1) |->
            (out_data[SMP_W-1:IDX_W] == '0 && out_data[IDX_W-1:0] < IDX_W'(N_CH)));

    p_drop_zero_count_r3: assert property (@(posedge clk) disable iff (rst)
        (is_end && out_data[SMP_W-1 -: 2] == 2'd0) |-> (out_data[CNT_W-1:0] == '0));

    p_full_count_r8: assert property (@(posedge clk) disable iff (rst)
        (is_end && out_data[SMP_W-1 -: 2] == 2'd1) |-> (out_data[CNT_W-1:0] == CNT_W'(N_CH)));

    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        is_end |-> (out_data[CNT_W-1:0] <= CNT_W'(N_CH) && out_data[SMP_W-1 -: 2] != 2'd3));

    p_idle_kind_r11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_kind == 2'd0));

endmodule

bind sr_zs_unit sr_zs_unit_chk #(.N_CH(N_CH), .SMP_W(SMP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_kind (out_kind),
    .out_data (out_data)
);

// File: tb/sr_zs_unit_tb_top.sv
module sr_zs_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 25;
    localparam int NS = 10;

    typedef struct {
        bit        v;
        bit [1:0]  k;
        bit [15:0] d;
        string     tag;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [5:0]          cfg_state_map = '0;
    logic [NS*12-1:0]    cfg_weights = '0;
    logic signed [32:0]  cfg_thresh = '0;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [1:0]          in_class = '0;
    logic [NS*16-1:0]    in_samples = '0;
    logic                out_valid;
    logic [1:0]          out_kind;
    logic [15:0]         out_data;

    int   checks = 0;
    int   bad = 0;
    bit   mon_en = 1'b0;
    bit   done = 1'b0;
    int   wgt [NS];
    exp_t exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_zs_unit dut_i (
        .clk(clk), .rst(rst), .cfg_state_map(cfg_state_map),
        .cfg_weights(cfg_weights), .cfg_thresh(cfg_thresh),
        .in_valid(in_valid), .in_ready(in_ready), .in_class(in_class),
        .in_samples(in_samples), .out_valid(out_valid),
        .out_kind(out_kind), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (valid,kind,data,ready)", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] gen(input int p, input int ch, input int t);
        return 16'((p * 977 + ch * 131 + t * 37) ^ (ch << 10) ^ (p << 13));
    endfunction

    function automatic longint fir_sum(input int p, input int ch);
        longint s = 0;
        for (int t = 0; t < NS; t++) s += longint'(gen(p, ch, t)) * longint'(wgt[t]);
        return s;
    endfunction

    task automatic load_weights();
        for (int t = 0; t < NS; t++) cfg_weights[t*12 +: 12] = 12'(wgt[t]);
    endtask

    // reference model: per-cycle expectation of one tower
    task automatic build_expected(input int p, input logic [1:0] cls, input string ovr);
        exp_t e;
        int   slot = (cls == 2'd3) ? 2 : int'(cls);
        int   code = int'(cfg_state_map[slot*2 +: 2]);
        int   st = (code == 3) ? 1 : code;
        int   cnt = 0;
        int   first = exp_q.size();
        if (st != 0) begin
            for (int ch = 0; ch < NC; ch++) begin
                bit fwd = (st == 1) || (fir_sum(p, ch) >= longint'(cfg_thresh));
                if (fwd) begin
                    cnt++;
                    e.v = 1; e.k = 2'd1; e.d = 16'(ch);
                    e.tag = (ovr != "") ? ovr : ((st == 2) ? "R5 R7" : "R4 R7");
                    exp_q.push_back(e);
                    for (int t = 0; t < NS; t++) begin
                        e.v = 1; e.k = 2'd2; e.d = gen(p, ch, t);
                        e.tag = (ovr != "") ? ovr : "R4";
                        exp_q.push_back(e);
                    end
                end else begin
                    e.v = 0; e.k = 2'd0; e.d = '0;
                    e.tag = (ovr != "") ? ovr : "R6";
                    exp_q.push_back(e);
                end
            end
        end
        e.v = 1; e.k = 2'd3;
        e.d = {2'(st), 9'b0, 5'(cnt)};
        e.tag = (ovr != "") ? ovr : ((st == 0) ? "R3" : "R8");
        exp_q.push_back(e);
        exp_q[first].tag = {exp_q[first].tag, " R12"};
    endtask

    task automatic send_tower(input int p, input logic [1:0] cls, input bit gaps,
                              input bit junk, input string ovr);
        bit rdy;
        for (int ch = 0; ch < NC; ch++) begin
            if (gaps && (ch % 4 == 1)) begin
                in_valid = 1'b0;
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_class = (ch == 0) ? cls : ~cls;  // R2: class on later beats ignored
            for (int t = 0; t < NS; t++) in_samples[t*16 +: 16] = gen(p, ch, t);
            do begin
                @(negedge clk); rdy = in_ready;
                @(posedge clk); #1;
            end while (!rdy);
        end
        build_expected(p, cls, ovr);
        if (junk) begin
            // R1: beats offered while busy must not be taken
            in_samples = '1;
            in_class   = 2'd0;
            repeat (3) begin @(posedge clk); #1; end
        end
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            if (exp_q.size() > 0) begin
                exp_t e;
                bit   ok;
                e  = exp_q.pop_front();
                ok = (out_valid == e.v) && !in_ready &&
                     (!e.v || (out_kind == e.k && out_data == e.d));
                chk(ok, {e.tag, " R1"}, {out_valid, out_kind, out_data, in_ready},
                    {e.v, e.k, e.d, 1'b0});
            end else begin
                chk(!out_valid && in_ready, "R11 R1",
                    {out_valid, out_kind, out_data, in_ready}, {1'b0, 2'b0, 16'h0, 1'b1});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL R1 watchdog expired, %0d expectations pending", exp_q.size());
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        longint s7;
        wgt = '{-3, 5, 12, 40, 60, 40, 12, 5, -3, -1};
        load_weights();
        cfg_state_map = {2'd1, 2'd2, 2'd0};  // high full, medium suppress, low drop
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && in_ready, "R10", {out_valid, out_kind, out_data, in_ready},
            {1'b0, 2'b0, 16'h0, 1'b1});
        mon_en = 1'b1;
        @(posedge clk); #1;

        send_tower(1, 2'd0, 1'b0, 1'b0, "R3");          // R3 drop
        s7 = fir_sum(2, 7);
        cfg_thresh = 33'(s7);                            // R5 equality keeps channel 7
        send_tower(2, 2'd1, 1'b1, 1'b1, "");
        while (exp_q.size() > 0) @(posedge clk);
        #1 cfg_thresh = 33'(s7 + 1);                     // R5 one above drops channel 7
        send_tower(2, 2'd1, 1'b0, 1'b0, "");
        send_tower(3, 2'd2, 1'b0, 1'b1, "");             // R4 full
        send_tower(4, 2'd3, 1'b1, 1'b0, "R2");           // R2 reserved class
        while (exp_q.size() > 0) @(posedge clk);
        #1 cfg_state_map = {2'd3, 2'd2, 2'd2};          // R9 code 3 entry, low suppress
        send_tower(5, 2'd2, 1'b0, 1'b0, "R9");
        wgt = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 0};
        while (exp_q.size() > 0) @(posedge clk);
        #1 load_weights();
        cfg_thresh = 33'sd30000;                         // R5 single-tap amplitude test
        send_tower(6, 2'd0, 1'b1, 1'b0, "");
        while (exp_q.size() > 0) @(posedge clk);
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule